// File: doc/BRIEF.md
# Successive-Approximation Conversion and Power-Mode Sequencer

This block runs one channel conversion of a 12-bit successive-approximation converter and keeps track of its power state. A serial front end hands it the decoded command fields (input channel, range bit, bipolar flag and a two-bit power request) together with an acquire strobe. The block then steers the input multiplexer and holds the track/hold in track. A later convert strobe switches the track/hold to hold and starts a binary search. The search drives a trial code to an external DAC and comparator, and reads back one comparator decision per clock.

When the search ends, the block latches the result for readout. The result is straight binary in unipolar mode. In bipolar mode the MSB is inverted, which gives two's complement. A power-down request carried by the command is applied only once the conversion has finished. An active-low hardware shutdown input forces full power-down at once and abandons any conversion in progress. A wake strobe from the front end brings the block back from a software power-down. The front end raises this strobe on the bit that follows a START condition, a matching address and a write bit.

Top module: `sar_conv_sequencer`

## Requirements
- R1: After reset, track_en=0, busy=0, mux_sel=0, result=0 and pwr_mode=2'b00 (normal).
- R2: An accepted acq_stb latches chan_sel onto mux_sel in plain binary (0 selects input 0, 7 selects input 7) and range_sel onto range_hi, and raises track_en on the next clock.
- R3: conv_stb while track_en=1 drops track_en and raises busy on the next clock. The first trial code on dac_code is 12'h800. busy then stays high for exactly 12 clocks, with one bit decided per clock, MSB first.
- R4: conv_stb while track_en=0 is ignored; busy stays low.
- R5: With bipolar=0 the latched result equals the straight-binary code found by the search. A trial bit is kept when cmp_in=1, which means the input is at least the trial code.
- R6: With bipolar=1 the result is the search code with its MSB inverted (two's complement): search code 000 gives 800, FFF gives 7FF, 800 gives 000.
- R7: acq_stb while busy=1 is ignored; mux_sel keeps its value and track_en stays low.
- R8: The power request (pd_sel) is latched with the acquire strobe. 2'b00 and 2'b01 keep normal mode, 2'b10 selects standby (pwr_mode=2'b10) and 2'b11 selects full power-down (pwr_mode=2'b11). The request takes effect on the clock that ends the conversion; pwr_mode stays 2'b00 while busy.
- R9: In a software power-down, acq_stb is ignored. A wake_stb returns pwr_mode to 2'b00 on the next clock.
- R10: While shdn_n=0, pwr_mode reads 2'b11 with no clock delay. busy and track_en are cleared at the next clock. Raising shdn_n again returns pwr_mode to 2'b00.
- R11: result keeps its last value through standby, full power-down and hardware shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shdn_n | input | 1 | Hardware shutdown, active low |
| acq_stb | input | 1 | Acquire strobe: latch fields, start tracking |
| chan_sel | input | CHW | Input channel number |
| range_sel | input | 1 | Full-scale range select |
| bipolar | input | 1 | 1 = two's-complement result |
| pd_sel | input | 2 | Power request applied after the conversion |
| conv_stb | input | 1 | Convert strobe: hold and start the search |
| wake_stb | input | 1 | Wake from software power-down |
| cmp_in | input | 1 | Comparator: 1 when the input is at least dac_code |
| track_en | output | 1 | Track/hold in track (1) or hold (0) |
| mux_sel | output | CHW | Multiplexer select |
| range_hi | output | 1 | Latched range select |
| dac_code | output | RES | Current trial code |
| busy | output | 1 | Conversion in progress |
| result | output | RES | Latched conversion result |
| pwr_mode | output | 2 | 00 normal, 10 standby, 11 full power-down |

## Verification
A slip in the step counter shows at the ports as a busy pulse that is not 12 clocks long. It also shows as a result that differs from the bench's input code, and both appear at the end of the first conversion. A wrong bit-keep decision or a wrong starting trial shows on dac_code one clock after the convert strobe. Codes at both ends of the scale and at mid-scale expose it in the final result. A power request applied too early shows as a non-normal pwr_mode while busy is high. A shutdown path that failed to clear the sequencer leaves busy or track_en high one clock after shdn_n falls.

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer #(
  parameter int RES = 12,
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shdn_n,
  input  logic           acq_stb,
  input  logic [CHW-1:0] chan_sel,
  input  logic           range_sel,
  input  logic           bipolar,
  input  logic [1:0]     pd_sel,
  input  logic           conv_stb,
  input  logic           wake_stb,
  input  logic           cmp_in,
  output logic           track_en,
  output logic [CHW-1:0] mux_sel,
  output logic           range_hi,
  output logic [RES-1:0] dac_code,
  output logic           busy,
  output logic [RES-1:0] result,
  output logic [1:0]     pwr_mode
);
  localparam int SW = $clog2(RES);
  localparam logic [1:0] PM_NORM = 2'b00;
  localparam logic [1:0] PM_FULL = 2'b11;

  logic [RES-1:0] sar_q;
  logic [SW-1:0]  step_q;
  logic           bip_q;
  logic [1:0]     pd_q, pwr_q;

  wire acq_ok  = acq_stb && !busy && (pwr_q == PM_NORM);
  wire conv_ok = conv_stb && track_en;

  wire [RES-1:0] bit_mask = RES'(1) << step_q;
  wire [RES-1:0] decided  = cmp_in ? sar_q : (sar_q & ~bit_mask);
  wire [RES-1:0] next_try = (step_q == '0) ? decided : (decided | (bit_mask >> 1));

  assign dac_code = sar_q;
  assign pwr_mode = shdn_n ? pwr_q : PM_FULL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      track_en <= 1'b0;
      mux_sel  <= '0;
      range_hi <= 1'b0;
      busy     <= 1'b0;
      result   <= '0;
      sar_q    <= '0;
      step_q   <= '0;
      bip_q    <= 1'b0;
      pd_q     <= PM_NORM;
      pwr_q    <= PM_NORM;
    end else if (!shdn_n) begin
      track_en <= 1'b0;
      busy     <= 1'b0;
      sar_q    <= '0;
      step_q   <= '0;
      pwr_q    <= PM_NORM;
    end else begin
      if (acq_ok) begin
        track_en <= 1'b1;
        mux_sel  <= chan_sel;
        range_hi <= range_sel;
        bip_q    <= bipolar;
        pd_q     <= pd_sel;
      end
      if (conv_ok) begin
        track_en <= 1'b0;
        busy     <= 1'b1;
        sar_q    <= {1'b1, {(RES-1){1'b0}}};
        step_q   <= SW'(RES-1);
      end else if (busy) begin
        sar_q  <= next_try;
        step_q <= step_q - 1'b1;
        if (step_q == '0) begin
          busy   <= 1'b0;
          result <= {decided[RES-1] ^ bip_q, decided[RES-2:0]};
          if (pd_q[1]) pwr_q <= pd_q;
        end
      end
      if (wake_stb && !busy && (pwr_q != PM_NORM)) pwr_q <= PM_NORM;
    end
  end
endmodule

module sar_conv_sequencer_chk #(
  parameter int RES = 12,
  parameter int CHW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           shdn_n,
  input logic           track_en,
  input logic           busy,
  input logic [CHW-1:0] mux_sel,
  input logic [RES-1:0] dac_code,
  input logic [1:0]     pwr_mode
);
  logic [7:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else        busy_cnt <= busy ? busy_cnt + 8'd1 : 8'd0;
  end

  p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt < 8'(RES)));

  p_hold_on_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!track_en && $past(track_en)));

  p_first_trial_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (dac_code == {1'b1, {(RES-1){1'b0}}}));

  p_mux_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mux_sel));

  p_pd_deferred_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && shdn_n) |-> (pwr_mode == 2'b00));

  p_mode_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode != 2'b01);

  p_shdn_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (!busy && !track_en));
endmodule

bind sar_conv_sequencer sar_conv_sequencer_chk #(.RES(RES), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .track_en(track_en), .busy(busy),
  .mux_sel(mux_sel), .dac_code(dac_code), .pwr_mode(pwr_mode)
);

// File: tb/sim_sar_conv_sequencer.sv
module sim_sar_conv_sequencer;
  logic clk = 1'b0, rst_n = 1'b0, shdn_n = 1'b1;
  logic acq_stb = 1'b0, range_sel = 1'b0, bipolar = 1'b0, conv_stb = 1'b0, wake_stb = 1'b0;
  logic [2:0]  chan_sel = '0;
  logic [1:0]  pd_sel = '0;
  logic [11:0] vin = '0;
  logic [11:0] last_res = '0;
  wire track_en, busy, range_hi, cmp_in;
  wire [2:0]  mux_sel;
  wire [11:0] dac_code, result;
  wire [1:0]  pwr_mode;
  int tests = 0, fails = 0, ncyc = 0;
  bit done = 1'b0;

  assign cmp_in = (dac_code <= vin);
  always #4 clk = ~clk;

  sar_conv_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .acq_stb(acq_stb), .chan_sel(chan_sel),
    .range_sel(range_sel), .bipolar(bipolar), .pd_sel(pd_sel), .conv_stb(conv_stb),
    .wake_stb(wake_stb), .cmp_in(cmp_in), .track_en(track_en), .mux_sel(mux_sel),
    .range_hi(range_hi), .dac_code(dac_code), .busy(busy), .result(result), .pwr_mode(pwr_mode)
  );

  // {chan[27:25], bipolar[24], input code[23:12], expected result[11:0]}
  localparam logic [27:0] VEC [8] = '{
    {3'd0, 1'b0, 12'h000, 12'h000},
    {3'd7, 1'b0, 12'hFFF, 12'hFFF},
    {3'd3, 1'b1, 12'h000, 12'h800},
    {3'd5, 1'b1, 12'hFFF, 12'h7FF},
    {3'd1, 1'b0, 12'hA5C, 12'hA5C},
    {3'd6, 1'b1, 12'h7FF, 12'hFFF},
    {3'd2, 1'b1, 12'h800, 12'h000},
    {3'd4, 1'b0, 12'h001, 12'h001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acquire(input logic [2:0] ch, input logic rng, input logic bip, input logic [1:0] pd);
    @(negedge clk);
    chan_sel = ch; range_sel = rng; bipolar = bip; pd_sel = pd; acq_stb = 1'b1;
    @(negedge clk);
    acq_stb = 1'b0;
  endtask

  task automatic start_conv;
    conv_stb = 1'b1;
    @(negedge clk);
    conv_stb = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 track", track_en, 0);
    chk("R1 busy", busy, 0);
    chk("R1 mux", mux_sel, 0);
    chk("R1 result", result, 0);
    chk("R1 pwr", pwr_mode, 2'b00);
    rst_n = 1'b1;

    @(negedge clk);
    start_conv();
    chk("R4 conv without track", busy, 0);

    for (int i = 0; i < 8; i++) begin
      vin = VEC[i][23:12];
      acquire(VEC[i][27:25], i[0], VEC[i][24], 2'b00);
      chk("R2 mux_sel", mux_sel, VEC[i][27:25]);
      chk("R2 range", range_hi, i[0]);
      chk("R2 track", track_en, 1);
      start_conv();
      chk("R3 busy up", busy, 1);
      chk("R3 track drop", track_en, 0);
      chk("R3 first trial", dac_code, 12'h800);
      wait_done(ncyc);
      chk("R3 busy length", ncyc, 12);
      chk(VEC[i][24] ? "R6 bipolar result" : "R5 unipolar result", result, VEC[i][11:0]);
      chk("R8 stays normal", pwr_mode, 2'b00);
    end

    // R7: acquire during a conversion is ignored
    vin = 12'h3C3;
    acquire(3'd2, 1'b0, 1'b0, 2'b01);
    start_conv();
    @(negedge clk);
    chan_sel = 3'd5; acq_stb = 1'b1;
    @(negedge clk);
    acq_stb = 1'b0;
    wait_done(ncyc);
    chk("R7 mux kept", mux_sel, 3'd2);
    chk("R7 no track", track_en, 0);
    chk("R5 result", result, 12'h3C3);
    chk("R8 pd 01 normal", pwr_mode, 2'b00);

    // R8 standby, deferred
    vin = 12'h456;
    acquire(3'd1, 1'b0, 1'b0, 2'b10);
    chk("R8 not yet", pwr_mode, 2'b00);
    start_conv();
    chk("R8 normal while busy", pwr_mode, 2'b00);
    wait_done(ncyc);
    chk("R8 standby", pwr_mode, 2'b10);
    chk("R11 result in standby", result, 12'h456);
    acquire(3'd6, 1'b1, 1'b1, 2'b00);
    chk("R9 acquire ignored", mux_sel, 3'd1);
    chk("R9 no track", track_en, 0);
    wake_stb = 1'b1;
    @(negedge clk);
    wake_stb = 1'b0;
    chk("R9 wake", pwr_mode, 2'b00);

    // R8 full power-down
    vin = 12'h9AB;
    acquire(3'd4, 1'b1, 1'b1, 2'b11);
    start_conv();
    wait_done(ncyc);
    chk("R8 full", pwr_mode, 2'b11);
    chk("R11 result in full", result, 12'h1AB);
    last_res = 12'h1AB;
    wake_stb = 1'b1;
    @(negedge clk);
    wake_stb = 1'b0;
    chk("R9 wake from full", pwr_mode, 2'b00);

    // R10 hardware shutdown aborts
    vin = 12'h123;
    acquire(3'd7, 1'b0, 1'b0, 2'b00);
    start_conv();
    repeat (3) @(negedge clk);
    shdn_n = 1'b0;
    #1;
    chk("R10 immediate full", pwr_mode, 2'b11);
    @(negedge clk);
    chk("R10 busy cleared", busy, 0);
    chk("R10 track cleared", track_en, 0);
    chk("R11 result kept", result, last_res);
    shdn_n = 1'b1;
    @(negedge clk);
    chk("R10 release", pwr_mode, 2'b00);
    acquire(3'd7, 1'b0, 1'b0, 2'b00);
    start_conv();
    wait_done(ncyc);
    chk("R5 after shutdown", result, 12'h123);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule